// File: doc/BRIEF.md
# Priority Instruction Dispatcher

This block is the central dispatcher for a group of autonomous processing units that share one memory of 24-bit words addressed by 15 bits. Each unit raises a one-cycle request pulse when it wants work. The dispatcher keeps every request pending until it is served. It picks the lowest-numbered pending unit and pulses a select line to that unit. It latches the status bit the unit returns and then either resumes the unit's saved program or starts the next program waiting in that unit's queue.

Once a program runs, the dispatcher fetches instruction words through a read port with one cycle of latency. It interprets each word until it reaches a directive, which it hands to the unit together with the unit index. It then clears that unit's request and scans again. A cut word forks work onto another unit: the target program address goes into that unit's queue and that unit's request is raised. The current unit is released and stays pending, so it resumes just after the cut once it wins arbitration again. Each unit owns a saved program address, a busy bit and a small queue of program header addresses. A live fetch pointer is loaded from the saved address on selection and written back on release.

Top module: `prio_dispatcher`

## Requirements
- R1: After reset no select line, memory read or directive strobe is active. Unit 0 is busy with its program address set to the boot address. All other units are available, and every queue is empty.
- R2: Among the pending requests, the lowest unit index is selected. Exactly one select bit rises, and it stays high for a single cycle.
- R3: The status bit the selected unit drives while it is selected is latched. If that bit is 1 (unit still executing), no word is fetched and the request stays pending.
- R4: A busy unit whose status bit is 0 resumes fetching at its saved program address. That address points just past the last word interpreted for it.
- R5: An available unit with a non-empty queue pops the oldest entry and becomes busy. Its first fetch is at that entry plus one, and entries leave in the order they were queued.
- R6: An available unit with an empty queue has its request dropped. No word is fetched and no directive is issued.
- R7: The word type sits in bits 23:21, with blank=0, address=1, branch=2, cut=3 and directive=4; other values act as blank. Blank and address words only advance the fetch address by one.
- R8: A branch word makes the next fetch use its low 15 bits.
- R9: A cut word (bits 20:18 name the target unit, bits 14:0 the target header address) appends the address to the target unit's queue and raises that unit's request. It also releases the current unit with its program address just past the cut and its request still pending.
- R10: A directive word is presented on the directive outputs for one cycle along with the index of the unit it belongs to. The unit's request is then cleared.
- R11: A directive with bit 20 set also makes its unit available. A cut aimed at a full queue is discarded and leaves the queue contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_UNITS | One-cycle instruction request pulse per unit |
| sel_o | output | NUM_UNITS | One-hot, one-cycle select of the unit being served |
| ustat_i | input | 1 | Status returned by the selected unit (1 = still executing) |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 15 | Memory word address |
| mem_rdata_i | input | 24 | Read data, valid the cycle after the strobe |
| dir_valid_o | output | 1 | Directive strobe |
| dir_unit_o | output | $clog2(NUM_UNITS) | Unit that receives the directive |
| dir_word_o | output | 24 | Directive word |

## Verification
The case that is hardest to reach from the ports is a cut aimed at a queue that is already full. The queue only fills through cuts that running programs execute, and the target must not consume any entry before the overflow arrives. The stimulus therefore boots unit 0 into a program that issues three cuts in a row to one unit whose queue holds two entries. Because unit 0 has the lower index, it keeps winning arbitration until it reaches its own directive. The target's later requests then show two programs delivered in order and a third request that produces nothing. The executing-status skip is reached by holding a unit's status high only while it is selected, which makes the dispatcher reselect it with no fetches until the status is released.

// File: rtl/disp_pkg.sv
package disp_pkg;

    localparam int AW = 15;
    localparam int DW = 24;

    localparam int TYPE_LSB     = 21;
    localparam int DIR_LAST_BIT = 20;
    localparam int CUT_UNIT_LSB = 18;

    typedef enum logic [2:0] {
        W_BLANK  = 3'd0,
        W_ADDR   = 3'd1,
        W_BRANCH = 3'd2,
        W_CUT    = 3'd3,
        W_DIR    = 3'd4
    } wtype_e;

    typedef enum logic [2:0] {
        S_SCAN,
        S_STAT,
        S_DECIDE,
        S_FETCH,
        S_EXEC
    } state_e;

    typedef struct packed {
        logic executing;
    } unit_stat_t;

    function automatic wtype_e word_type(input logic [DW-1:0] w);
        case (w[TYPE_LSB +: 3])
            3'd1:    return W_ADDR;
            3'd2:    return W_BRANCH;
            3'd3:    return W_CUT;
            3'd4:    return W_DIR;
            default: return W_BLANK;
        endcase
    endfunction

    function automatic logic [AW-1:0] word_addr(input logic [DW-1:0] w);
        return w[AW-1:0];
    endfunction

    function automatic logic dir_last(input logic [DW-1:0] w);
        return w[DIR_LAST_BIT];
    endfunction

endpackage

// File: rtl/disp_prio_pick.sv
module disp_prio_pick #(
    parameter int NUM_UNITS = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_UNITS-1:0]         pend_i,
    output logic                         any_o,
    output logic [$clog2(NUM_UNITS)-1:0] idx_o,
    output logic [NUM_UNITS-1:0]         onehot_o
);
    localparam int UIDX_W = $clog2(NUM_UNITS);

    always_comb begin
        any_o    = |pend_i;
        idx_o    = '0;
        for (int i = NUM_UNITS - 1; i >= 0; i--) begin
            if (pend_i[i]) idx_o = UIDX_W'(i);
        end
        onehot_o = pend_i & (~pend_i + 1'b1);
    end

    // R2: the isolated bit and the encoded index agree
    assert_pick_lowest_R2: assert property (@(posedge clk) disable iff (rst)
        any_o |-> (onehot_o[idx_o] && $onehot(onehot_o)));

endmodule

// File: rtl/disp_unit_file.sv
module disp_unit_file
    import disp_pkg::*;
#(
    parameter int NUM_UNITS   = 4,
    parameter int QUEUE_DEPTH = 2,
    parameter int BOOT_ADDR   = 0
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [$clog2(NUM_UNITS)-1:0] rd_idx,
    output logic [AW-1:0]                par_o,
    output logic                         busy_o,
    output logic                         q_empty_o,
    output logic [AW-1:0]                q_head_o,
    input  logic                         par_we,
    input  logic [AW-1:0]                par_wdata,
    input  logic                         busy_we,
    input  logic                         busy_wdata,
    input  logic                         pop,
    input  logic                         push,
    input  logic [$clog2(NUM_UNITS)-1:0] push_idx,
    input  logic [AW-1:0]                push_addr,
    output logic                         push_full_o
);
    localparam int UIDX_W = $clog2(NUM_UNITS);
    localparam int QIW    = $clog2(QUEUE_DEPTH);
    localparam int QPW    = QIW + 1;

    logic [AW-1:0] par_all   [NUM_UNITS];
    logic          busy_all  [NUM_UNITS];
    logic          empty_all [NUM_UNITS];
    logic          full_all  [NUM_UNITS];
    logic [AW-1:0] head_all  [NUM_UNITS];

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        logic [AW-1:0]  par_q;
        logic           busy_q;
        logic [AW-1:0]  slot_q [QUEUE_DEPTH];
        logic [QPW-1:0] hd_q, tl_q;
        logic           sel_rd, sel_wr;

        assign sel_rd = (rd_idx == UIDX_W'(u));
        assign sel_wr = (push_idx == UIDX_W'(u));

        always_ff @(posedge clk) begin
            if (rst) begin
                par_q  <= (u == 0) ? AW'(BOOT_ADDR) : '0;
                busy_q <= (u == 0);
                hd_q   <= '0;
                tl_q   <= '0;
            end else begin
                if (par_we && sel_rd)  par_q  <= par_wdata;
                if (busy_we && sel_rd) busy_q <= busy_wdata;
                if (pop && sel_rd)     hd_q   <= hd_q + 1'b1;
                if (push && sel_wr && !full_all[u]) begin
                    slot_q[tl_q[QIW-1:0]] <= push_addr;
                    tl_q <= tl_q + 1'b1;
                end
            end
        end

        assign par_all[u]   = par_q;
        assign busy_all[u]  = busy_q;
        assign empty_all[u] = (hd_q == tl_q);
        assign full_all[u]  = (hd_q[QIW] != tl_q[QIW]) &&
                              (hd_q[QIW-1:0] == tl_q[QIW-1:0]);
        assign head_all[u]  = slot_q[hd_q[QIW-1:0]];
    end

    assign par_o       = par_all[rd_idx];
    assign busy_o      = busy_all[rd_idx];
    assign q_empty_o   = empty_all[rd_idx];
    assign q_head_o    = head_all[rd_idx];
    assign push_full_o = full_all[push_idx];

    // R11: the controller never appends to a full queue
    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
        push |-> !push_full_o);

    // R5: the controller never pops an empty queue
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
        pop |-> !q_empty_o);

endmodule

// File: rtl/prio_dispatcher.sv
module prio_dispatcher
    import disp_pkg::*;
#(
    parameter int NUM_UNITS   = 4,
    parameter int QUEUE_DEPTH = 2,
    parameter int BOOT_ADDR   = 0
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_UNITS-1:0]         req_i,
    output logic [NUM_UNITS-1:0]         sel_o,
    input  logic                         ustat_i,
    output logic                         mem_rd_o,
    output logic [14:0]                  mem_addr_o,
    input  logic [23:0]                  mem_rdata_i,
    output logic                         dir_valid_o,
    output logic [$clog2(NUM_UNITS)-1:0] dir_unit_o,
    output logic [23:0]                  dir_word_o
);
    localparam int UIDX_W = $clog2(NUM_UNITS);

    state_e               state_q, state_d;
    logic [UIDX_W-1:0]    cur_q, cur_d;
    logic [AW-1:0]        apar_q, apar_d;
    unit_stat_t           ar_q, ar_d;
    logic [NUM_UNITS-1:0] pend_q, pend_clr, pend_set;
    logic [NUM_UNITS-1:0] sel_q, sel_d;
    logic                 dir_v_q, dir_v_d;
    logic [UIDX_W-1:0]    dir_u_q, dir_u_d;
    logic [DW-1:0]        dir_w_q, dir_w_d;

    logic                 pick_any;
    logic [UIDX_W-1:0]    pick_idx;
    logic [NUM_UNITS-1:0] pick_onehot;

    logic [AW-1:0]        uf_par, uf_head;
    logic                 uf_busy, uf_empty, uf_push_full;
    logic                 par_we, busy_we, busy_wdata, q_pop, q_push;
    logic [AW-1:0]        par_wdata;

    wtype_e               wt;
    logic [AW-1:0]        wf_addr;
    logic [UIDX_W-1:0]    cut_tgt;

    assign wt      = word_type(mem_rdata_i);
    assign wf_addr = word_addr(mem_rdata_i);
    assign cut_tgt = mem_rdata_i[CUT_UNIT_LSB +: UIDX_W];

    disp_prio_pick #(.NUM_UNITS(NUM_UNITS)) u_pick (
        .clk      (clk),
        .rst      (rst),
        .pend_i   (pend_q),
        .any_o    (pick_any),
        .idx_o    (pick_idx),
        .onehot_o (pick_onehot)
    );

    disp_unit_file #(
        .NUM_UNITS   (NUM_UNITS),
        .QUEUE_DEPTH (QUEUE_DEPTH),
        .BOOT_ADDR   (BOOT_ADDR)
    ) u_units (
        .clk         (clk),
        .rst         (rst),
        .rd_idx      (cur_q),
        .par_o       (uf_par),
        .busy_o      (uf_busy),
        .q_empty_o   (uf_empty),
        .q_head_o    (uf_head),
        .par_we      (par_we),
        .par_wdata   (par_wdata),
        .busy_we     (busy_we),
        .busy_wdata  (busy_wdata),
        .pop         (q_pop),
        .push        (q_push),
        .push_idx    (cut_tgt),
        .push_addr   (wf_addr),
        .push_full_o (uf_push_full)
    );

    always_comb begin
        state_d    = state_q;
        cur_d      = cur_q;
        apar_d     = apar_q;
        ar_d       = ar_q;
        sel_d      = '0;
        pend_clr   = '0;
        pend_set   = '0;
        par_we     = 1'b0;
        par_wdata  = apar_q;
        busy_we    = 1'b0;
        busy_wdata = 1'b0;
        q_pop      = 1'b0;
        q_push     = 1'b0;
        dir_v_d    = 1'b0;
        dir_u_d    = dir_u_q;
        dir_w_d    = dir_w_q;
        case (state_q)
            S_SCAN: begin
                if (pick_any) begin
                    cur_d   = pick_idx;
                    sel_d   = pick_onehot;
                    state_d = S_STAT;
                end
            end
            S_STAT: begin
                ar_d    = '{executing: ustat_i};
                state_d = S_DECIDE;
            end
            S_DECIDE: begin
                if (ar_q.executing) begin
                    state_d = S_SCAN;
                end else if (uf_busy) begin
                    apar_d  = uf_par;
                    state_d = S_FETCH;
                end else if (!uf_empty) begin
                    q_pop      = 1'b1;
                    apar_d     = uf_head + 1'b1;
                    par_we     = 1'b1;
                    par_wdata  = uf_head + 1'b1;
                    busy_we    = 1'b1;
                    busy_wdata = 1'b1;
                    state_d    = S_FETCH;
                end else begin
                    pend_clr[cur_q] = 1'b1;
                    state_d         = S_SCAN;
                end
            end
            S_FETCH: begin
                apar_d  = apar_q + 1'b1;
                state_d = S_EXEC;
            end
            S_EXEC: begin
                case (wt)
                    W_BRANCH: begin
                        apar_d  = wf_addr;
                        state_d = S_FETCH;
                    end
                    W_CUT: begin
                        q_push            = !uf_push_full;
                        pend_set[cut_tgt] = !uf_push_full;
                        par_we            = 1'b1;
                        state_d           = S_SCAN;
                    end
                    W_DIR: begin
                        dir_v_d         = 1'b1;
                        dir_u_d         = cur_q;
                        dir_w_d         = mem_rdata_i;
                        par_we          = 1'b1;
                        busy_we         = dir_last(mem_rdata_i);
                        busy_wdata      = 1'b0;
                        pend_clr[cur_q] = 1'b1;
                        state_d         = S_SCAN;
                    end
                    default: state_d = S_FETCH;
                endcase
            end
            default: state_d = S_SCAN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_SCAN;
            cur_q   <= '0;
            apar_q  <= '0;
            ar_q    <= '0;
            pend_q  <= '0;
            sel_q   <= '0;
            dir_v_q <= 1'b0;
            dir_u_q <= '0;
            dir_w_q <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            apar_q  <= apar_d;
            ar_q    <= ar_d;
            pend_q  <= (pend_q & ~pend_clr) | pend_set | req_i;
            sel_q   <= sel_d;
            dir_v_q <= dir_v_d;
            dir_u_q <= dir_u_d;
            dir_w_q <= dir_w_d;
        end
    end

    assign sel_o       = sel_q;
    assign mem_rd_o    = (state_q == S_FETCH);
    assign mem_addr_o  = apar_q;
    assign dir_valid_o = dir_v_q;
    assign dir_unit_o  = dir_u_q;
    assign dir_word_o  = dir_w_q;

    assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_o));

    assert_sel_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        (|sel_o) |=> (sel_o == '0));

    assert_no_fetch_on_select_R3: assert property (@(posedge clk) disable iff (rst)
        (|sel_o) |-> !mem_rd_o);

    assert_step_by_one_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_EXEC && (wt == W_ADDR || wt == W_BLANK))
            |=> (mem_rd_o && mem_addr_o == $past(mem_addr_o, 2) + 1'b1));

    assert_branch_target_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_EXEC && wt == W_BRANCH)
            |=> (mem_rd_o && mem_addr_o == $past(wf_addr)));

    assert_dir_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        dir_valid_o |=> !dir_valid_o);

    assert_dir_no_fetch_R10: assert property (@(posedge clk) disable iff (rst)
        dir_valid_o |-> !mem_rd_o);

endmodule

// File: tb/prio_dispatcher_bench.sv
module prio_dispatcher_bench;

    localparam int NU = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  req;
    logic [3:0]  sel_o;
    logic        ustat;
    logic [3:0]  exec_mask;
    logic        mem_rd_o;
    logic [14:0] mem_addr_o;
    logic [23:0] mem_rdata;
    logic        dir_valid_o;
    logic [1:0]  dir_unit_o;
    logic [23:0] dir_word_o;

    logic [23:0] mem [1024];

    typedef struct {
        int          unit;
        logic [23:0] word;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   rd_log[$];
    int   sel_log[$];
    int   tests = 0;
    int   fails = 0;
    int   rd_cnt = 0;
    int   dir_cnt = 0;

    always #2.5 clk = ~clk;

    prio_dispatcher #(.NUM_UNITS(NU), .QUEUE_DEPTH(2), .BOOT_ADDR(0)) u_prio_dispatcher (
        .clk         (clk),
        .rst         (rst),
        .req_i       (req),
        .sel_o       (sel_o),
        .ustat_i     (ustat),
        .mem_rd_o    (mem_rd_o),
        .mem_addr_o  (mem_addr_o),
        .mem_rdata_i (mem_rdata),
        .dir_valid_o (dir_valid_o),
        .dir_unit_o  (dir_unit_o),
        .dir_word_o  (dir_word_o)
    );

    assign ustat = |(sel_o & exec_mask);

    always @(posedge clk) begin
        if (mem_rd_o) mem_rdata <= mem[mem_addr_o[9:0]];
    end

    function automatic logic [23:0] w_adr(input int a);
        return {3'd1, 6'd0, 15'(a)};
    endfunction
    function automatic logic [23:0] w_br(input int a);
        return {3'd2, 6'd0, 15'(a)};
    endfunction
    function automatic logic [23:0] w_cut(input int u, input int a);
        return {3'd3, 3'(u), 3'd0, 15'(a)};
    endfunction
    function automatic logic [23:0] w_dir(input bit last, input int p);
        return {3'd4, last, 20'(p)};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic expect_dir(input int unit, input logic [23:0] word, input string tag);
        exp_t e;
        e.unit = unit;
        e.word = word;
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    task automatic cmp_log(input int got[$], input int exp[$], input string tag,
                           input string what);
        bit ok;
        ok = (got.size() == exp.size());
        if (ok) foreach (exp[i]) if (got[i] != exp[i]) ok = 0;
        check(ok, tag, $sformatf("%s (size %0d)", what, got.size()),
              (got.size() > 0) ? got[got.size()-1] : -1,
              (exp.size() > 0) ? exp[exp.size()-1] : -1);
    endtask

    task automatic pulse_req(input logic [3:0] m);
        @(negedge clk) req = m;
        @(negedge clk) req = 4'b0000;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor and scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_rd_o) begin
                rd_log.push_back(int'(mem_addr_o));
                rd_cnt++;
            end
            for (int i = 0; i < NU; i++) if (sel_o[i]) sel_log.push_back(i);
            if (dir_valid_o) begin : score
                exp_t e;
                dir_cnt++;
                tests++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R10: unexpected directive unit=%0d word=%h expected none",
                             dir_unit_o, dir_word_o);
                end else begin
                    e = exp_q.pop_front();
                    if (int'(dir_unit_o) != e.unit || dir_word_o != e.word) begin
                        fails++;
                        $display("FAIL %s: directive unit=%0d word=%h expected unit=%0d word=%h",
                                 e.tag, dir_unit_o, dir_word_o, e.unit, e.word);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin
        int rd0, dir0;
        rst = 1'b1;
        req = 4'b0000;
        exec_mask = 4'b0000;
        for (int a = 0; a < 1024; a++) mem[a] = 24'd0;
        // unit 0 boot program
        mem['h00] = w_adr('h100);
        mem['h01] = 24'd0;
        mem['h02] = w_cut(1, 'h40);
        mem['h03] = w_cut(2, 'h60);
        mem['h04] = w_br('h10);
        mem['h10] = w_dir(0, 'hA1);
        mem['h11] = w_cut(3, 'h80);
        mem['h12] = w_cut(3, 'h88);
        mem['h13] = w_cut(3, 'h90);
        mem['h14] = w_dir(1, 'hA2);
        // queued programs (header word is blank)
        mem['h41] = w_adr('h200);
        mem['h42] = w_dir(1, 'hB1);
        mem['h61] = w_dir(0, 'hC1);
        mem['h62] = w_dir(1, 'hC2);
        mem['h81] = w_dir(0, 'hD1);
        mem['h82] = w_dir(1, 'hD2);
        mem['h89] = w_dir(0, 'hE1);
        mem['h8A] = w_dir(1, 'hE2);
        mem['h91] = w_dir(1, 'hF1);
        settle(5);
        rst = 1'b0;

        // R1: idle after reset
        repeat (6) begin
            @(negedge clk);
            check(sel_o == 0 && !mem_rd_o && !dir_valid_o, "R1",
                  "idle outputs after reset", {sel_o, mem_rd_o, dir_valid_o}, 0);
        end

        // Phase A: boot, cuts, branch, queued starts
        rd_log.delete(); sel_log.delete();
        expect_dir(0, w_dir(0, 'hA1), "R8");
        expect_dir(1, w_dir(1, 'hB1), "R5");
        expect_dir(2, w_dir(0, 'hC1), "R5");
        pulse_req(4'b0001);
        settle(150);
        check(exp_q.size() == 0, "R10", "phase A directives outstanding", exp_q.size(), 0);
        cmp_log(rd_log, '{0, 1, 2, 3, 4, 'h10, 'h41, 'h42, 'h61}, "R7",
                "fetch sequence with blank/address/branch/cut");
        cmp_log(sel_log, '{0, 0, 0, 1, 2}, "R2", "selection order after cuts (R9)");

        // Phase B: unit 2 reports executing (R3), then resumes (R4)
        rd_log.delete(); sel_log.delete();
        rd0 = rd_cnt; dir0 = dir_cnt;
        exec_mask = 4'b0100;
        pulse_req(4'b0100);
        settle(40);
        check(rd_cnt == rd0, "R3", "fetches while unit executing", rd_cnt - rd0, 0);
        check(dir_cnt == dir0, "R3", "directives while unit executing", dir_cnt - dir0, 0);
        begin
            bit all2;
            all2 = (sel_log.size() >= 2);
            foreach (sel_log[i]) if (sel_log[i] != 2) all2 = 0;
            check(all2, "R3", "request kept pending, unit 2 reselected",
                  sel_log.size(), 2);
        end
        rd_log.delete();
        expect_dir(2, w_dir(1, 'hC2), "R4");
        exec_mask = 4'b0000;
        settle(40);
        cmp_log(rd_log, '{'h62}, "R4", "resume at saved program address");

        // Phase C: three cuts into a two-deep queue (R11), resume after cut (R9)
        rd_log.delete(); sel_log.delete();
        expect_dir(0, w_dir(1, 'hA2), "R9");
        expect_dir(3, w_dir(0, 'hD1), "R5");
        pulse_req(4'b0001);
        settle(120);
        cmp_log(rd_log, '{'h11, 'h12, 'h13, 'h14, 'h81}, "R9", "fetches across repeated cuts");
        cmp_log(sel_log, '{0, 0, 0, 0, 3}, "R2", "lower index wins over cut target");
        expect_dir(3, w_dir(1, 'hD2), "R4");
        pulse_req(4'b1000);
        settle(40);
        expect_dir(3, w_dir(0, 'hE1), "R5");
        pulse_req(4'b1000);
        settle(40);
        expect_dir(3, w_dir(1, 'hE2), "R11");
        pulse_req(4'b1000);
        settle(40);
        rd0 = rd_cnt; dir0 = dir_cnt;
        pulse_req(4'b1000);
        settle(40);
        check(rd_cnt == rd0, "R11", "fetches for discarded cut", rd_cnt - rd0, 0);
        check(dir_cnt == dir0, "R11", "directives for discarded cut", dir_cnt - dir0, 0);

        // Phase D: simultaneous requests from idle units with empty queues
        sel_log.delete();
        rd0 = rd_cnt; dir0 = dir_cnt;
        pulse_req(4'b1011);
        settle(40);
        cmp_log(sel_log, '{0, 1, 3}, "R2", "priority order of simultaneous requests");
        check(rd_cnt == rd0, "R6", "fetches for empty-queue units", rd_cnt - rd0, 0);
        check(dir_cnt == dir0, "R6", "directives for empty-queue units", dir_cnt - dir0, 0);
        check(exp_q.size() == 0, "R10", "directives still outstanding", exp_q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule